// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address for one access at a time. Each access carries a kind (read, write or execute) and a privilege flag. With translation switched on, the block reads up to two 32-bit descriptors from memory over a request/response port. It finishes with one of three results: a physical address with a page size and a permission set, a numbered fault, or a malformed-descriptor error. Two cases skip the table walk. When translation is off, the address passes through unchanged. A privileged access to the lower half of the address space is redirected into the upper half.

A faulting walk stores its fault number and the virtual address in two status registers. In the same cycle it raises an instruction abort for execute accesses, or a data abort for the other kinds. The block does not cache translations, does not model the memory behind its port, and does not perform exception entry.

Top module: `pgwalk_top`

## Requirements
- R1: After reset, `req_ready` is 1, and `done_valid`, `mem_req_valid`, `abort_instr` and `abort_data` are 0. `fault_status` and `fault_addr` are 0.
- R2: When `cfg_mmu_on` is 0, an access completes with no memory read. It gives `done_pa` equal to the VA, `done_perm` = 3'b111 and `done_big_page` = 0.
- R3: When `cfg_mmu_on` is 1, a privileged access (`req_user` = 0) with VA[31] = 0 completes with no memory read. It gives `done_pa` = VA | 0x8000_0000 and `done_perm` = 3'b111. A user access, or any access with VA[31] = 1, walks the table, even if VA[31] = 0.
- R4: The first descriptor read uses address {`cfg_table_base`[31:12], VA[31:22], 2'b00}. In every descriptor, bits [1:0] hold the type and bit 2 is the present flag.
- R5: A first-level descriptor of type 3 maps a 4 MB page. If present, `done_pa` = {desc[31:22], VA[21:0]} and `done_big_page` = 1. If absent, the walk faults with code 0x0B.
- R6: A first-level descriptor of type 0 points to a second-level table. If it is absent, the walk faults with code 0x05. If present, the second read uses address {desc[31:12], VA[21:12], 2'b00}.
- R7: A second-level descriptor that is absent faults with code 0x08. A present second-level descriptor of type 0 gives `done_pa` = {desc[31:12], VA[11:0]} and `done_big_page` = 0.
- R8: The final descriptor grants read with bit 8, write with bit 7 and execute with bit 6. These appear on `done_perm` as {read, write, execute}. A user access that lacks its grant faults: read (`req_access` 0) gives 0x11, write (1) gives 0x12, execute (2) gives 0x13.
- R9: A privileged walk never takes a permission fault. It completes with whatever grants the descriptor holds.
- R10: A fault is reported in the `done_valid` cycle with `done_fault` = 1 and `done_code` set to the fault number. At the same point `fault_status` takes the code and `fault_addr` takes the VA. The abort is a one-cycle pulse in that cycle: `abort_instr` for execute accesses, `abort_data` otherwise.
- R11: A descriptor type other than 3 or 0 at the first level, or a nonzero type in a present second-level descriptor, completes with `done_err` = 1. In that case there is no fault, no abort, and the fault registers keep their values.
- R12: `req_ready` is 1 only while idle, so only one access is in flight. Each descriptor read is a one-cycle `mem_req_valid` pulse. Each result is a one-cycle `done_valid` pulse, followed by a return to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_mmu_on | input | 1 | Translation enable |
| cfg_table_base | input | 32 | First-level table base; bits [11:0] are ignored |
| req_valid | input | 1 | Access request |
| req_ready | output | 1 | Walker idle and able to accept |
| req_va | input | 32 | Virtual address |
| req_access | input | 2 | 0 read, 1 write, 2 execute |
| req_user | input | 1 | 1 for a user access, 0 for privileged |
| mem_req_valid | output | 1 | Descriptor read request, one-cycle pulse |
| mem_req_addr | output | 32 | Descriptor address |
| mem_rsp_valid | input | 1 | Descriptor data valid |
| mem_rsp_data | input | 32 | Descriptor word |
| done_valid | output | 1 | Result valid, one-cycle pulse |
| done_pa | output | 32 | Physical address, 0 on fault or error |
| done_big_page | output | 1 | 1 for a 4 MB page, 0 for a 4 KB page |
| done_perm | output | 3 | {read, write, execute} grants |
| done_fault | output | 1 | Result is a fault |
| done_code | output | 8 | Fault number, 0 if no fault |
| done_err | output | 1 | Malformed descriptor type |
| fault_status | output | 8 | Code of the last fault |
| fault_addr | output | 32 | VA of the last fault |
| abort_instr | output | 1 | Execute-access abort pulse |
| abort_data | output | 1 | Read/write-access abort pulse |

## Verification
The properties assume that memory answers only while the walker waits for a descriptor, and gives exactly one `mem_rsp_valid` pulse per `mem_req_valid`. They also assume that `req_access` never takes the value 3 on a user access. The bench's memory responder answers each read once, one cycle after the request pulse. It drives requests for one cycle and only while `req_ready` is high. It uses access kinds 0 to 2 only, so every result reaches the checks under these same assumptions.

// File: rtl/pgw_pkg.sv
package pgw_pkg;

  localparam int VA_W    = 32;
  localparam int DESC_W  = 32;
  localparam int CODE_W  = 8;
  localparam int PERM_W  = 3;
  localparam int ACC_W   = 2;

  localparam int BIG_SHIFT  = 22;
  localparam int PAGE_SHIFT = 12;

  localparam int BIT_PRESENT = 2;
  localparam int BIT_RD      = 8;
  localparam int BIT_WR      = 7;
  localparam int BIT_EX      = 6;

  localparam logic [1:0] TYPE_BIG   = 2'd3;
  localparam logic [1:0] TYPE_TABLE = 2'd0;

  localparam logic [ACC_W-1:0] ACC_RD = 2'd0;
  localparam logic [ACC_W-1:0] ACC_WR = 2'd1;
  localparam logic [ACC_W-1:0] ACC_EX = 2'd2;

  localparam logic [CODE_W-1:0] FLT_L2_ABSENT  = 8'h05;
  localparam logic [CODE_W-1:0] FLT_PAGE_ABS   = 8'h08;
  localparam logic [CODE_W-1:0] FLT_BIG_ABSENT = 8'h0B;
  localparam logic [CODE_W-1:0] FLT_NO_READ    = 8'h11;
  localparam logic [CODE_W-1:0] FLT_NO_WRITE   = 8'h12;
  localparam logic [CODE_W-1:0] FLT_NO_EXEC    = 8'h13;

  localparam logic [VA_W-1:0] IO_WINDOW = 32'h8000_0000;

  typedef enum logic [2:0] {
    ST_IDLE, ST_L1_REQ, ST_L1_WAIT, ST_L2_REQ, ST_L2_WAIT, ST_DONE
  } walk_state_e;

  typedef struct packed {
    logic              go_l2;
    logic [VA_W-1:0]   pa;
    logic              big;
    logic [PERM_W-1:0] perm;
    logic              fault;
    logic [CODE_W-1:0] code;
    logic              err;
  } walk_outcome_t;

  function automatic logic [VA_W-1:0] l1_addr(input logic [VA_W-1:0] base,
                                              input logic [VA_W-1:0] va);
    return {base[VA_W-1:PAGE_SHIFT], va[VA_W-1:BIG_SHIFT], 2'b00};
  endfunction

  function automatic logic [VA_W-1:0] l2_addr(input logic [DESC_W-1:0] desc,
                                              input logic [VA_W-1:0] va);
    return {desc[DESC_W-1:PAGE_SHIFT], va[BIG_SHIFT-1:PAGE_SHIFT], 2'b00};
  endfunction

  function automatic logic [VA_W-1:0] big_pa(input logic [DESC_W-1:0] desc,
                                             input logic [VA_W-1:0] va);
    return {desc[DESC_W-1:BIG_SHIFT], va[BIG_SHIFT-1:0]};
  endfunction

  function automatic logic [VA_W-1:0] page_pa(input logic [DESC_W-1:0] desc,
                                              input logic [VA_W-1:0] va);
    return {desc[DESC_W-1:PAGE_SHIFT], va[PAGE_SHIFT-1:0]};
  endfunction

  function automatic logic [PERM_W-1:0] grants(input logic [DESC_W-1:0] desc);
    return {desc[BIT_RD], desc[BIT_WR], desc[BIT_EX]};
  endfunction

  function automatic logic [CODE_W-1:0] perm_fault(input logic [DESC_W-1:0] desc,
                                                   input logic [ACC_W-1:0] acc,
                                                   input logic user);
    logic [CODE_W-1:0] c;
    c = '0;
    if (user) begin
      case (acc)
        ACC_RD:  if (!desc[BIT_RD]) c = FLT_NO_READ;
        ACC_WR:  if (!desc[BIT_WR]) c = FLT_NO_WRITE;
        ACC_EX:  if (!desc[BIT_EX]) c = FLT_NO_EXEC;
        default: c = '0;
      endcase
    end
    return c;
  endfunction

endpackage

// File: rtl/pgw_eval.sv
module pgw_eval
  import pgw_pkg::*;
(
  input  logic                level2,
  input  logic [DESC_W-1:0]   desc,
  input  logic [VA_W-1:0]     va,
  input  logic [ACC_W-1:0]    acc,
  input  logic                user,
  output walk_outcome_t       outcome
);

  logic [CODE_W-1:0] pcode;
  logic              present;
  logic [1:0]        dtype;

  assign present = desc[BIT_PRESENT];
  assign dtype   = desc[1:0];
  assign pcode   = perm_fault(desc, acc, user);

  always_comb begin
    outcome = '0;
    if (!level2) begin
      if (dtype == TYPE_BIG) begin
        if (!present) begin
          outcome.fault = 1'b1;
          outcome.code  = FLT_BIG_ABSENT;
        end else if (pcode != '0) begin
          outcome.fault = 1'b1;
          outcome.code  = pcode;
        end else begin
          outcome.pa   = big_pa(desc, va);
          outcome.big  = 1'b1;
          outcome.perm = grants(desc);
        end
      end else if (dtype == TYPE_TABLE) begin
        if (!present) begin
          outcome.fault = 1'b1;
          outcome.code  = FLT_L2_ABSENT;
        end else begin
          outcome.go_l2 = 1'b1;
        end
      end else begin
        outcome.err = 1'b1;
      end
    end else begin
      if (!present) begin
        outcome.fault = 1'b1;
        outcome.code  = FLT_PAGE_ABS;
      end else if (dtype != TYPE_TABLE) begin
        outcome.err = 1'b1;
      end else if (pcode != '0) begin
        outcome.fault = 1'b1;
        outcome.code  = pcode;
      end else begin
        outcome.pa   = page_pa(desc, va);
        outcome.perm = grants(desc);
      end
    end
  end

endmodule

// File: rtl/pgw_ctrl.sv
module pgw_ctrl
  import pgw_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_mmu_on,
  input  logic [VA_W-1:0]     cfg_table_base,
  input  logic                req_valid,
  input  logic [VA_W-1:0]     req_va,
  input  logic [ACC_W-1:0]    req_access,
  input  logic                req_user,
  output logic                req_ready,
  output logic                mem_req_valid,
  output logic [VA_W-1:0]     mem_req_addr,
  input  logic                mem_rsp_valid,
  input  logic [DESC_W-1:0]   mem_rsp_data,
  input  walk_outcome_t       outcome,
  output logic                eval_level2,
  output logic [VA_W-1:0]     walk_va,
  output logic [ACC_W-1:0]    walk_acc,
  output logic                walk_user,
  output logic                in_done,
  output logic                walk_finish,
  output walk_outcome_t       result
);

  walk_state_e       state;
  logic [VA_W-1:0]   base_q;
  logic [DESC_W-1:0] l1_desc_q;
  logic              l1_take;
  logic              l2_take;

  assign req_ready     = (state == ST_IDLE);
  assign in_done       = (state == ST_DONE);
  assign eval_level2   = (state == ST_L2_WAIT);
  assign mem_req_valid = (state == ST_L1_REQ) || (state == ST_L2_REQ);
  assign mem_req_addr  = (state == ST_L2_REQ) ? l2_addr(l1_desc_q, walk_va)
                                              : l1_addr(base_q, walk_va);

  assign l1_take     = (state == ST_L1_WAIT) && mem_rsp_valid;
  assign l2_take     = (state == ST_L2_WAIT) && mem_rsp_valid;
  assign walk_finish = (l1_take && !outcome.go_l2) || l2_take;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      base_q    <= '0;
      l1_desc_q <= '0;
      walk_va   <= '0;
      walk_acc  <= '0;
      walk_user <= 1'b0;
      result    <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (req_valid) begin
            walk_va   <= req_va;
            walk_acc  <= req_access;
            walk_user <= req_user;
            base_q    <= cfg_table_base;
            result    <= '0;
            if (!cfg_mmu_on) begin
              result.pa   <= req_va;
              result.perm <= '1;
              state       <= ST_DONE;
            end else if (!req_user && !req_va[VA_W-1]) begin
              result.pa   <= req_va | IO_WINDOW;
              result.perm <= '1;
              state       <= ST_DONE;
            end else begin
              state <= ST_L1_REQ;
            end
          end
        end
        ST_L1_REQ: state <= ST_L1_WAIT;
        ST_L1_WAIT: begin
          if (mem_rsp_valid) begin
            if (outcome.go_l2) begin
              l1_desc_q <= mem_rsp_data;
              state     <= ST_L2_REQ;
            end else begin
              result <= outcome;
              state  <= ST_DONE;
            end
          end
        end
        ST_L2_REQ: state <= ST_L2_WAIT;
        ST_L2_WAIT: begin
          if (mem_rsp_valid) begin
            result <= outcome;
            state  <= ST_DONE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/pgw_fault_log.sv
module pgw_fault_log
  import pgw_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                log_en,
  input  logic [CODE_W-1:0]   log_code,
  input  logic [VA_W-1:0]     log_va,
  input  logic [ACC_W-1:0]    log_acc,
  output logic [CODE_W-1:0]   fault_status,
  output logic [VA_W-1:0]     fault_addr,
  output logic                abort_instr,
  output logic                abort_data
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fault_status <= '0;
      fault_addr   <= '0;
      abort_instr  <= 1'b0;
      abort_data   <= 1'b0;
    end else begin
      abort_instr <= log_en && (log_acc == ACC_EX);
      abort_data  <= log_en && (log_acc != ACC_EX);
      if (log_en) begin
        fault_status <= log_code;
        fault_addr   <= log_va;
      end
    end
  end

endmodule

// File: rtl/pgwalk_top.sv
module pgwalk_top
  import pgw_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_mmu_on,
  input  logic [VA_W-1:0]     cfg_table_base,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [VA_W-1:0]     req_va,
  input  logic [ACC_W-1:0]    req_access,
  input  logic                req_user,
  output logic                mem_req_valid,
  output logic [VA_W-1:0]     mem_req_addr,
  input  logic                mem_rsp_valid,
  input  logic [DESC_W-1:0]   mem_rsp_data,
  output logic                done_valid,
  output logic [VA_W-1:0]     done_pa,
  output logic                done_big_page,
  output logic [PERM_W-1:0]   done_perm,
  output logic                done_fault,
  output logic [CODE_W-1:0]   done_code,
  output logic                done_err,
  output logic [CODE_W-1:0]   fault_status,
  output logic [VA_W-1:0]     fault_addr,
  output logic                abort_instr,
  output logic                abort_data
);

  walk_outcome_t     outcome;
  walk_outcome_t     result;
  logic              eval_level2;
  logic [VA_W-1:0]   walk_va;
  logic [ACC_W-1:0]  walk_acc;
  logic              walk_user;
  logic              in_done;
  logic              walk_finish;
  logic              evt_fault_log;

  pgw_eval u_eval (
    .level2  (eval_level2),
    .desc    (mem_rsp_data),
    .va      (walk_va),
    .acc     (walk_acc),
    .user    (walk_user),
    .outcome (outcome)
  );

  pgw_ctrl u_ctrl (
    .clk            (clk),
    .rst_n          (rst_n),
    .cfg_mmu_on     (cfg_mmu_on),
    .cfg_table_base (cfg_table_base),
    .req_valid      (req_valid),
    .req_va         (req_va),
    .req_access     (req_access),
    .req_user       (req_user),
    .req_ready      (req_ready),
    .mem_req_valid  (mem_req_valid),
    .mem_req_addr   (mem_req_addr),
    .mem_rsp_valid  (mem_rsp_valid),
    .mem_rsp_data   (mem_rsp_data),
    .outcome        (outcome),
    .eval_level2    (eval_level2),
    .walk_va        (walk_va),
    .walk_acc       (walk_acc),
    .walk_user      (walk_user),
    .in_done        (in_done),
    .walk_finish    (walk_finish),
    .result         (result)
  );

  assign evt_fault_log = walk_finish && outcome.fault;

  pgw_fault_log u_flog (
    .clk          (clk),
    .rst_n        (rst_n),
    .log_en       (evt_fault_log),
    .log_code     (outcome.code),
    .log_va       (walk_va),
    .log_acc      (walk_acc),
    .fault_status (fault_status),
    .fault_addr   (fault_addr),
    .abort_instr  (abort_instr),
    .abort_data   (abort_data)
  );

  assign done_valid    = in_done;
  assign done_pa       = result.pa;
  assign done_big_page = result.big;
  assign done_perm     = result.perm;
  assign done_fault    = result.fault;
  assign done_code     = result.code;
  assign done_err      = result.err;

endmodule

// File: rtl/pgwalk_checker.sv
module pgwalk_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       req_ready,
  input logic       mem_req_valid,
  input logic       done_valid,
  input logic       done_fault,
  input logic       done_err,
  input logic [7:0] done_code,
  input logic [7:0] fault_status,
  input logic       abort_instr,
  input logic       abort_data,
  input logic       walk_user,
  input logic       evt_fault_log
);

  p_done_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |=> !done_valid);

  p_memreq_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |=> !mem_req_valid);

  p_ready_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!done_valid && !mem_req_valid));

  p_abort_exclusive_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(abort_instr && abort_data));

  p_abort_on_fault_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (abort_instr || abort_data) |-> (done_valid && done_fault));

  p_status_match_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (done_valid && done_fault) |-> (fault_status == done_code));

  p_log_then_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
    evt_fault_log |=> (done_valid && done_fault));

  p_err_clean_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (done_valid && done_err) |-> (!done_fault && !abort_instr && !abort_data));

  p_priv_no_perm_fault_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (done_valid && done_fault && !walk_user) |->
      (done_code != 8'h11 && done_code != 8'h12 && done_code != 8'h13));

endmodule

bind pgwalk_top pgwalk_checker u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_ready     (req_ready),
  .mem_req_valid (mem_req_valid),
  .done_valid    (done_valid),
  .done_fault    (done_fault),
  .done_err      (done_err),
  .done_code     (done_code),
  .fault_status  (fault_status),
  .abort_instr   (abort_instr),
  .abort_data    (abort_data),
  .walk_user     (walk_user),
  .evt_fault_log (evt_fault_log)
);

// File: tb/pgwalk_top_tb.sv
module pgwalk_top_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_mmu_on = 1'b0;
  logic [31:0] cfg_table_base = 32'h0010_0ABC;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_va = '0;
  logic [1:0]  req_access = '0;
  logic        req_user = 1'b0;
  logic        mem_req_valid;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic        done_valid;
  logic [31:0] done_pa;
  logic        done_big_page;
  logic [2:0]  done_perm;
  logic        done_fault;
  logic [7:0]  done_code;
  logic        done_err;
  logic [7:0]  fault_status;
  logic [31:0] fault_addr;
  logic        abort_instr;
  logic        abort_data;

  int tests = 0;
  int fails = 0;

  logic [31:0] l1_desc, l2_desc;
  logic [31:0] rd_addr [2];
  int          rd_cnt;
  logic [31:0] g_pa, g_faddr;
  logic [2:0]  g_perm;
  logic [7:0]  g_code, g_fstat;
  logic        g_big, g_fault, g_err, g_ai, g_ad, g_seen;

  always #4 clk = ~clk;

  pgwalk_top u_dut (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_l1(input logic [31:0] va);
    return (cfg_table_base & 32'hFFFF_F000) | ((va >> 20) & 32'h0000_0FFC);
  endfunction

  function automatic logic [31:0] exp_l2(input logic [31:0] d, input logic [31:0] va);
    return (d & 32'hFFFF_F000) | ((va >> 10) & 32'h0000_0FFC);
  endfunction

  task automatic xlate(input logic [31:0] va, input logic [1:0] acc, input logic user);
    @(negedge clk);
    req_valid = 1'b1; req_va = va; req_access = acc; req_user = user;
    @(negedge clk);
    req_valid = 1'b0;
    rd_cnt = 0; g_seen = 1'b0;
    for (int i = 0; i < 40 && !g_seen; i++) begin
      if (done_valid) begin
        g_seen = 1'b1;
        g_pa = done_pa; g_big = done_big_page; g_perm = done_perm;
        g_fault = done_fault; g_code = done_code; g_err = done_err;
        g_ai = abort_instr; g_ad = abort_data;
        g_fstat = fault_status; g_faddr = fault_addr;
      end else if (mem_req_valid) begin
        if (rd_cnt < 2) rd_addr[rd_cnt] = mem_req_addr;
        @(negedge clk);
        mem_rsp_valid = 1'b1;
        mem_rsp_data = (rd_cnt == 0) ? l1_desc : l2_desc;
        rd_cnt++;
        @(negedge clk);
        mem_rsp_valid = 1'b0;
      end else begin
        @(negedge clk);
      end
    end
    chk("R12 result arrives", {31'd0, g_seen}, 32'd1);
    @(negedge clk);
    chk("R12 done one cycle", {31'd0, done_valid}, 32'd0);
    chk("R12 ready after done", {31'd0, req_ready}, 32'd1);
  endtask

  task automatic t_reset;
    chk("R1 ready", {31'd0, req_ready}, 32'd1);
    chk("R1 done", {31'd0, done_valid}, 32'd0);
    chk("R1 memreq", {31'd0, mem_req_valid}, 32'd0);
    chk("R1 status", {24'd0, fault_status}, 32'd0);
    chk("R1 faddr", fault_addr, 32'd0);
    chk("R1 aborts", {30'd0, abort_instr, abort_data}, 32'd0);
  endtask

  task automatic t_mmu_off;
    cfg_mmu_on = 1'b0;
    xlate(32'h1234_5678, 2'd1, 1'b1);
    chk("R2 pa", g_pa, 32'h1234_5678);
    chk("R2 perm", {29'd0, g_perm}, 32'd7);
    chk("R2 size", {31'd0, g_big}, 32'd0);
    chk("R2 no reads", rd_cnt, 0);
    cfg_mmu_on = 1'b1;
  endtask

  task automatic t_io_window;
    xlate(32'h1234_5678, 2'd0, 1'b0);
    chk("R3 pa", g_pa, 32'h9234_5678);
    chk("R3 perm", {29'd0, g_perm}, 32'd7);
    chk("R3 no reads", rd_cnt, 0);
  endtask

  task automatic t_big_page;
    logic [31:0] va;
    va = 32'hC012_3456;
    l1_desc = 32'hABC0_0000 | 32'h100 | 32'h4 | 32'h3;
    xlate(va, 2'd0, 1'b1);
    chk("R4 l1 addr", rd_addr[0], exp_l1(va));
    chk("R5 pa", g_pa, (l1_desc & 32'hFFC0_0000) | (va & 32'h003F_FFFF));
    chk("R5 size", {31'd0, g_big}, 32'd1);
    chk("R8 perm", {29'd0, g_perm}, 32'd4);
    chk("R5 reads", rd_cnt, 1);
    l1_desc = 32'hABC0_0000 | 32'h1C0 | 32'h3;
    xlate(va, 2'd1, 1'b1);
    chk("R5 absent code", {24'd0, g_code}, 32'h0B);
    chk("R10 data abort", {30'd0, g_ai, g_ad}, 32'd1);
    chk("R10 faddr", g_faddr, va);
    chk("R10 status", {24'd0, g_fstat}, 32'h0B);
    chk("R5 fault pa", g_pa, 32'd0);
  endtask

  task automatic t_two_level;
    logic [31:0] va;
    va = 32'h0040_5ABC;
    l1_desc = 32'h0020_0000 | 32'h4;
    l2_desc = 32'h7777_7000 | 32'h080 | 32'h4;
    xlate(va, 2'd1, 1'b1);
    chk("R3 user low walks", rd_cnt, 2);
    chk("R4 l1 addr", rd_addr[0], exp_l1(va));
    chk("R6 l2 addr", rd_addr[1], exp_l2(l1_desc, va));
    chk("R7 pa", g_pa, 32'h7777_7ABC);
    chk("R7 size", {31'd0, g_big}, 32'd0);
    chk("R8 perm", {29'd0, g_perm}, 32'd2);
    chk("R7 no fault", {31'd0, g_fault}, 32'd0);
    l1_desc = 32'h0020_0000;
    xlate(va, 2'd0, 1'b1);
    chk("R6 absent code", {24'd0, g_code}, 32'h05);
    chk("R6 one read", rd_cnt, 1);
    l1_desc = 32'h0020_0004;
    l2_desc = 32'h7777_71C0;
    xlate(32'h8040_5000, 2'd2, 1'b0);
    chk("R7 absent code", {24'd0, g_code}, 32'h08);
    chk("R10 instr abort", {30'd0, g_ai, g_ad}, 32'd2);
  endtask

  task automatic t_perms;
    l1_desc = 32'h0020_0004;
    l2_desc = 32'h5555_5000 | 32'h4;
    xlate(32'hF000_1000, 2'd0, 1'b1);
    chk("R8 no read", {24'd0, g_code}, 32'h11);
    xlate(32'hF000_1000, 2'd1, 1'b1);
    chk("R8 no write", {24'd0, g_code}, 32'h12);
    xlate(32'hF000_1000, 2'd2, 1'b1);
    chk("R8 no exec", {24'd0, g_code}, 32'h13);
    chk("R10 exec abort", {30'd0, g_ai, g_ad}, 32'd2);
    chk("R10 status", {24'd0, g_fstat}, 32'h13);
    xlate(32'hF000_1234, 2'd2, 1'b0);
    chk("R9 priv no fault", {31'd0, g_fault}, 32'd0);
    chk("R9 priv perm", {29'd0, g_perm}, 32'd0);
    chk("R9 priv pa", g_pa, 32'h5555_5234);
  endtask

  task automatic t_bad_type;
    l1_desc = 32'h0020_0005;
    xlate(32'hC000_0000, 2'd0, 1'b1);
    chk("R11 l1 err", {31'd0, g_err}, 32'd1);
    chk("R11 no fault", {31'd0, g_fault}, 32'd0);
    chk("R11 no abort", {30'd0, g_ai, g_ad}, 32'd0);
    chk("R11 status kept", {24'd0, g_fstat}, 32'h13);
    chk("R11 faddr kept", g_faddr, 32'hF000_1000);
    l1_desc = 32'h0020_0004;
    l2_desc = 32'h3333_31C6;
    xlate(32'hC000_0000, 2'd0, 1'b1);
    chk("R11 l2 err", {31'd0, g_err}, 32'd1);
    chk("R11 l2 no abort", {30'd0, g_ai, g_ad}, 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_mmu_off();
    t_io_window();
    t_big_page();
    t_two_level();
    t_perms();
    t_bad_type();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule